// File: doc/BRIEF.md
# Per-Lane Data Eye Edge Sweeper

This block locates the left and right edges of the data-valid window for up to nine byte lanes of a memory channel. It runs four programmed stages one after another. A coarse stage walks every lane in steps of 4 until each lane reaches its target result. A fine stage then walks back in steps of 1 until each lane flips, which pins the edge. Each lane advances on its own. A lane stops moving, for the rest of the stage, as soon as it has seen its target. The top lane carries check bits and takes part only when ECC is enabled.

For each candidate delay setting the block sends a request to an external pattern tester. The request carries all lane delays and a per-lane flag that marks negative delays. The tester answers with one or more response beats, one per chip select that shares the delay setting. Both directions use valid/ready. A request stays on the bus, unchanged, until the tester raises `tst_req_ready`. The block then raises `tst_rsp_ready` and keeps it high until it accepts a beat marked `tst_rsp_last`. It issues no new request while a response is still open. The tester may hold back either `tst_req_ready` or `tst_rsp_valid` for any number of cycles.

At the end the block pulses `done`. It then presents the per-lane lower edges on `eye_lo` and the upper edges on `eye_hi`, or raises `err` when some lane has no usable window.

Top module: `eye_edge_sweeper`

## Requirements
- R1: A `start` pulse while idle latches `rd_dir` and `ecc_en`, raises `busy` and runs four stages in order. A `start` while busy is ignored. Stage table, given as (begin or "continue", end, step, target, edge). Write runs (rd_dir=0): (0, 31, +4, pass, lower), (continue, 0, -1, fail, lower), (31, 0, -4, pass, upper), (continue, 31, +1, fail, upper). Read runs (rd_dir=1): (0, -32, -4, fail, lower), (continue, 31, +1, pass, lower), and then the same two upper stages as write runs. `done` is a one-cycle pulse, and `busy` is low in that cycle.
- R2: A stage with an explicit begin value loads it into every lane and tests it before taking any step. So the first request of every run carries delay 0 on all lanes. A "continue" stage first steps from the lane's stored edge and then tests.
- R3: After each test a lane becomes found when its merged result equals the stage target (1 = pass). A found lane keeps its delay until the stage ends. The stage ends when every lane is found.
- R4: Before each step, the stage ends if any lane that is not yet found sits at the end delay. If the target of that stage is pass, `err` is set.
- R5: A lane less than one step from the end delay moves to the end delay rather than past it. Every requested delay lies in -32..31.
- R6: Delays are 8-bit two's complement. Lane i sits at bits [8i+7:8i] of `tst_req_dly`, `eye_lo` and `eye_hi`. A lane with a negative delay has its `tst_req_neg` bit set, and its result comes from `tst_rsp_alt_pass`. Other lanes take their result from `tst_rsp_pass`.
- R7: When a fine stage (step ±1) with target fail ends with all lanes found, every active lane moves back by one step. The stored edge is then the last passing delay.
- R8: The block ANDs per-lane results over all beats of a response, up to and including the beat with `tst_rsp_last`=1.
- R9: With `ecc_en`=0, lane 8 counts as found from the start of each stage. Its response bits do not affect any result.
- R10: Once `err` is set, the remaining stages are skipped and `done` follows. The block issues exactly as many tests as the stage rules call for. `eye_lo` and `eye_hi` are valid only when `err`=0.
- R11: The request is held stable while `tst_req_valid` is high and `tst_req_ready` is low. `tst_req_valid` and `tst_rsp_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| rd_dir | input | 1 | 1 selects the read stage table, 0 the write table |
| ecc_en | input | 1 | 1 includes lane 8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | No usable window found in the last run |
| tst_req_valid | output | 1 | Test request valid |
| tst_req_ready | input | 1 | Tester accepts the request |
| tst_req_dly | output | LANES*8 | Per-lane signed delays to apply |
| tst_req_neg | output | LANES | Per-lane negative-delay flags |
| tst_rsp_valid | input | 1 | Response beat valid |
| tst_rsp_ready | output | 1 | Block accepts response beats |
| tst_rsp_pass | input | LANES | Per-lane result of the normal compare |
| tst_rsp_alt_pass | input | LANES | Per-lane result of the alternate compare |
| tst_rsp_last | input | 1 | Final beat of this response |
| eye_lo | output | LANES*8 | Per-lane lower edge |
| eye_hi | output | LANES*8 | Per-lane upper edge |

## Verification
The sweep gives each lane its own window, staggered across lanes, in both directions. It runs with and without ECC, with one to three chip-select beats per response, and with irregular back-pressure on both handshakes. Wrong stage order, missing back-off, missing clamping or missing lane freezing all show up as edges or test counts that disagree with the bench's stage model. Directed cases separate the error paths (a window that falls between coarse grid points, and a window that lies wholly below zero) from the quiet end-stops (windows reaching -32 or 31). With ECC off, lane 8 always answers fail and must not matter, and the normal and alternate compares answer opposite values, so using the wrong one flips the lane.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;
  localparam int DLY_W      = 8;
  localparam int NUM_STAGES = 4;
  localparam int STG_W      = $clog2(NUM_STAGES);
  localparam int COARSE     = 4;
  localparam int FINE       = 1;
  localparam int DLY_LO     = -32;
  localparam int DLY_HI     = 31;

  typedef logic signed [DLY_W-1:0] dly_t;

  typedef enum logic [1:0] {
    LOP_HOLD,
    LOP_LOAD,
    LOP_STEP,
    LOP_BACK
  } lane_op_e;

  typedef struct packed {
    logic cont;       // continue from the stored edge
    dly_t bgn;        // begin value when cont is 0
    dly_t fin;        // end delay
    dly_t step;       // signed step
    logic want_pass;  // target result
    logic right;      // 1 works on the upper edge
  } stage_t;

  function automatic stage_t mk_stage(logic cont, int bgn, int fin, int step,
                                      logic want_pass, logic right);
    stage_t s;
    s.cont      = cont;
    s.bgn       = dly_t'(bgn);
    s.fin       = dly_t'(fin);
    s.step      = dly_t'(step);
    s.want_pass = want_pass;
    s.right     = right;
    return s;
  endfunction
endpackage

// File: rtl/eye_stage_tab.sv
module eye_stage_tab
  import eye_sweep_pkg::*;
(
  input  logic             rd,
  input  logic [STG_W-1:0] idx,
  output stage_t           cfg
);
  always_comb begin
    case (idx)
      2'd0: cfg = rd ? mk_stage(1'b0, 0, DLY_LO, -COARSE, 1'b0, 1'b0)
                     : mk_stage(1'b0, 0, DLY_HI,  COARSE, 1'b1, 1'b0);
      2'd1: cfg = rd ? mk_stage(1'b1, 0, DLY_HI,  FINE,   1'b1, 1'b0)
                     : mk_stage(1'b1, 0, 0,      -FINE,   1'b0, 1'b0);
      2'd2: cfg = mk_stage(1'b0, DLY_HI, 0, -COARSE, 1'b1, 1'b1);
      default: cfg = mk_stage(1'b1, 0, DLY_HI, FINE, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/eye_lane.sv
module eye_lane
  import eye_sweep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lane_op_e op,
  input  logic     en,
  input  logic     right,
  input  dly_t     bgn,
  input  dly_t     fin,
  input  dly_t     step,
  output dly_t     lo_q,
  output dly_t     hi_q,
  output logic     at_fin,
  output logic     neg
);
  dly_t cur, nxt;
  logic signed [DLY_W:0] gap, gap_abs, step_abs;

  always_comb begin
    cur      = right ? hi_q : lo_q;
    gap      = {fin[DLY_W-1], fin} - {cur[DLY_W-1], cur};
    gap_abs  = gap[DLY_W] ? -gap : gap;
    step_abs = step[DLY_W-1] ? -{step[DLY_W-1], step} : {step[DLY_W-1], step};
    nxt      = cur;
    case (op)
      LOP_LOAD: nxt = bgn;
      LOP_STEP: if (en) nxt = (gap_abs < step_abs) ? fin : cur + step;
      LOP_BACK: if (en) nxt = cur - step;
      default:  nxt = cur;
    endcase
  end

  assign at_fin = (cur == fin);
  assign neg    = cur[DLY_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (right) begin
      hi_q <= nxt;
    end else begin
      lo_q <= nxt;
    end
  end
endmodule

// File: rtl/eye_merge.sv
module eye_merge #(
  parameter int LANES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             beat,
  input  logic [LANES-1:0] pass_n,
  input  logic [LANES-1:0] pass_a,
  input  logic [LANES-1:0] neg,
  output logic [LANES-1:0] acc_q
);
  logic [LANES-1:0] pick;
  assign pick = (pass_n & ~neg) | (pass_a & neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '1;
    else if (clr)  acc_q <= '1;
    else if (beat) acc_q <= acc_q & pick;
  end
endmodule

// File: rtl/eye_edge_sweeper.sv
module eye_edge_sweeper
  import eye_sweep_pkg::*;
#(
  parameter int LANES = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rd_dir,
  input  logic                   ecc_en,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   tst_req_valid,
  input  logic                   tst_req_ready,
  output logic [LANES*DLY_W-1:0] tst_req_dly,
  output logic [LANES-1:0]       tst_req_neg,
  input  logic                   tst_rsp_valid,
  output logic                   tst_rsp_ready,
  input  logic [LANES-1:0]       tst_rsp_pass,
  input  logic [LANES-1:0]       tst_rsp_alt_pass,
  input  logic                   tst_rsp_last,
  output logic [LANES*DLY_W-1:0] eye_lo,
  output logic [LANES*DLY_W-1:0] eye_hi
);
  localparam int DW = DLY_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_STEP, S_REQ, S_RSP, S_EVAL, S_NEXT
  } st_e;

  st_e              st;
  logic [STG_W-1:0] stg;
  logic             rd_q, ecc_q, err_q, done_q;
  logic [LANES-1:0] found, found_nxt, act, at_fin, neg, lane_en, acc;
  logic             blocked, all_found, fine;
  lane_op_e         lop;
  stage_t           cfg;
  dly_t             lo_d [LANES];
  dly_t             hi_d [LANES];

  eye_stage_tab u_tab (.rd(rd_q), .idx(stg), .cfg(cfg));

  // the top lane is the check-bit lane
  assign act = {ecc_q, {(LANES-1){1'b1}}};

  assign fine      = (cfg.step == dly_t'(FINE)) || (cfg.step == dly_t'(-FINE));
  assign blocked   = |(at_fin & ~found);
  assign found_nxt = found | ~(acc ^ {LANES{cfg.want_pass}});
  assign all_found = &found_nxt;

  always_comb begin
    lop = LOP_HOLD;
    case (st)
      S_LOAD: if (!cfg.cont) lop = LOP_LOAD;
      S_STEP: if (!blocked) lop = LOP_STEP;
      S_EVAL: if (all_found && fine && !cfg.want_pass) lop = LOP_BACK;
      default: lop = LOP_HOLD;
    endcase
  end

  assign lane_en = (lop == LOP_BACK) ? act : ~found;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    eye_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (lop),
      .en     (lane_en[g]),
      .right  (cfg.right),
      .bgn    (cfg.bgn),
      .fin    (cfg.fin),
      .step   (cfg.step),
      .lo_q   (lo_d[g]),
      .hi_q   (hi_d[g]),
      .at_fin (at_fin[g]),
      .neg    (neg[g])
    );
    assign tst_req_dly[g*DW +: DW] = cfg.right ? hi_d[g] : lo_d[g];
    assign eye_lo[g*DW +: DW]      = lo_d[g];
    assign eye_hi[g*DW +: DW]      = hi_d[g];
  end

  eye_merge #(.LANES(LANES)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st == S_REQ),
    .beat   (tst_rsp_valid && tst_rsp_ready),
    .pass_n (tst_rsp_pass),
    .pass_a (tst_rsp_alt_pass),
    .neg    (neg),
    .acc_q  (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stg    <= '0;
      rd_q   <= 1'b0;
      ecc_q  <= 1'b0;
      found  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd_q  <= rd_dir;
          ecc_q <= ecc_en;
          stg   <= '0;
          err_q <= 1'b0;
          st    <= S_LOAD;
        end
        S_LOAD: begin
          found <= ~act;
          st    <= cfg.cont ? S_STEP : S_REQ;
        end
        S_STEP: begin
          if (blocked) begin
            if (cfg.want_pass) err_q <= 1'b1;
            st <= S_NEXT;
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ: if (tst_req_ready) st <= S_RSP;
        S_RSP: if (tst_rsp_valid && tst_rsp_last) st <= S_EVAL;
        S_EVAL: begin
          found <= found_nxt;
          st    <= all_found ? S_NEXT : S_STEP;
        end
        S_NEXT: begin
          if (err_q || stg == STG_W'(NUM_STAGES-1)) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            stg <= stg + 1'b1;
            st  <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign done          = done_q;
  assign err           = err_q;
  assign tst_req_valid = (st == S_REQ);
  assign tst_rsp_ready = (st == S_RSP);
  assign tst_req_neg   = neg;
endmodule

// File: rtl/eye_edge_sweeper_chk.sv
module eye_edge_sweeper_chk
  import eye_sweep_pkg::*;
#(
  parameter int LANES = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   tst_req_valid,
  input logic                   tst_req_ready,
  input logic [LANES*DLY_W-1:0] tst_req_dly,
  input logic [LANES-1:0]       tst_req_neg,
  input logic                   tst_rsp_ready
);
  localparam int DW = DLY_W;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tst_req_valid && !tst_req_ready |=>
      tst_req_valid && $stable(tst_req_dly) && $stable(tst_req_neg));

  a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(tst_req_valid && tst_rsp_ready));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  for (genvar g = 0; g < LANES; g++) begin : g_rng
    dly_t d;
    assign d = tst_req_dly[g*DW +: DW];
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      tst_req_valid |-> (d >= dly_t'(DLY_LO)) && (d <= dly_t'(DLY_HI)));
  end
endmodule

bind eye_edge_sweeper eye_edge_sweeper_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .tst_req_valid (tst_req_valid),
  .tst_req_ready (tst_req_ready),
  .tst_req_dly   (tst_req_dly),
  .tst_req_neg   (tst_req_neg),
  .tst_rsp_ready (tst_rsp_ready)
);

// File: tb/eye_edge_sweeper_tb.sv
module eye_edge_sweeper_tb;
  import eye_sweep_pkg::*;
  localparam int NL = 9;
  localparam int DW = DLY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0, rd_dir = 1'b0, ecc_en = 1'b0;
  logic busy, done, err;
  logic tst_req_valid, tst_rsp_ready;
  logic tst_req_ready = 1'b0;
  logic [NL*DW-1:0] tst_req_dly, eye_lo, eye_hi;
  logic [NL-1:0] tst_req_neg;
  logic tst_rsp_valid = 1'b0, tst_rsp_last = 1'b0;
  logic [NL-1:0] tst_rsp_pass = '0, tst_rsp_alt_pass = '0;

  eye_edge_sweeper #(.LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_dir(rd_dir), .ecc_en(ecc_en),
    .busy(busy), .done(done), .err(err),
    .tst_req_valid(tst_req_valid), .tst_req_ready(tst_req_ready),
    .tst_req_dly(tst_req_dly), .tst_req_neg(tst_req_neg),
    .tst_rsp_valid(tst_rsp_valid), .tst_rsp_ready(tst_rsp_ready),
    .tst_rsp_pass(tst_rsp_pass), .tst_rsp_alt_pass(tst_rsp_alt_pass),
    .tst_rsp_last(tst_rsp_last), .eye_lo(eye_lo), .eye_hi(eye_hi)
  );

  int checks = 0, errors = 0;
  int eye_l [NL];
  int eye_r [NL];
  int cfg_ncs = 1;
  bit cfg_rd = 0, cfg_ecc = 1;
  int req_cnt = 0;
  int seed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit lane_on(input int i);
    return (i < NL-1) || cfg_ecc;
  endfunction

  // window seen through chip select k alone
  function automatic bit cs_pass(input int i, input int d, input int k);
    return (d >= eye_l[i] + k) && (d <= eye_r[i] - (k % 2));
  endfunction

  function automatic bit in_eye(input int i, input int d);
    bit r = 1'b1;
    for (int k = 0; k < cfg_ncs; k++) if (!cs_pass(i, d, k)) r = 1'b0;
    return r;
  endfunction

  task automatic stage_ref(input bit rd, input int s, output bit cont, output int bg,
                           output int fn, output int st, output bit wp, output bit rt);
    rt = (s >= 2);
    case (s)
      0: if (rd) begin cont=0; bg=0; fn=-32; st=-4; wp=0; end
         else    begin cont=0; bg=0; fn=31;  st=4;  wp=1; end
      1: if (rd) begin cont=1; bg=0; fn=31;  st=1;  wp=1; end
         else    begin cont=1; bg=0; fn=0;   st=-1; wp=0; end
      2: begin cont=0; bg=31; fn=0;  st=-4; wp=1; end
      default: begin cont=1; bg=0; fn=31; st=1; wp=0; end
    endcase
  endtask

  task automatic model(output bit e, output int lo[NL], output int hi[NL], output int nreq);
    int cur [NL];
    bit fnd [NL];
    bit cont, wp, rt, blk, all, dostep;
    int bg, fn, st;
    e = 0; nreq = 0;
    for (int i = 0; i < NL; i++) begin lo[i] = 0; hi[i] = 0; end
    for (int s = 0; s < 4 && !e; s++) begin
      stage_ref(cfg_rd, s, cont, bg, fn, st, wp, rt);
      for (int i = 0; i < NL; i++) begin
        cur[i] = rt ? hi[i] : lo[i];
        fnd[i] = !lane_on(i);
        if (!cont) cur[i] = bg;
      end
      dostep = cont;
      while (1'b1) begin
        if (dostep) begin
          blk = 0;
          for (int i = 0; i < NL; i++) if (!fnd[i] && cur[i] == fn) blk = 1;
          if (blk) begin
            if (wp) e = 1;
            break;
          end
          for (int i = 0; i < NL; i++)
            if (!fnd[i]) cur[i] = (iabs(fn - cur[i]) < iabs(st)) ? fn : cur[i] + st;
        end
        dostep = 1;
        nreq++;
        for (int i = 0; i < NL; i++) if (!fnd[i] && in_eye(i, cur[i]) == wp) fnd[i] = 1;
        all = 1;
        for (int i = 0; i < NL; i++) if (!fnd[i]) all = 0;
        if (all) begin
          if (iabs(st) == 1 && !wp)
            for (int i = 0; i < NL; i++) if (lane_on(i)) cur[i] = cur[i] - st;
          break;
        end
      end
      for (int i = 0; i < NL; i++) if (rt) hi[i] = cur[i]; else lo[i] = cur[i];
    end
  endtask

  // pattern tester model
  initial begin
    int d [NL];
    bit bad_rng, bad_neg, bad_first, p;
    forever begin
      @(negedge clk);
      if (tst_req_valid) begin
        bad_rng = 0; bad_neg = 0; bad_first = 0;
        for (int i = 0; i < NL; i++) begin
          d[i] = int'($signed(tst_req_dly[i*DW +: DW]));
          if (lane_on(i)) begin
            if (d[i] < -32 || d[i] > 31) bad_rng = 1;
            if (tst_req_neg[i] != (d[i] < 0)) bad_neg = 1;
            if (req_cnt == 0 && d[i] != 0) bad_first = 1;
          end
        end
        chk(!bad_rng, "R5", "request delay range", bad_rng, 0);
        chk(!bad_neg, "R6", "negative flag vs delay sign", bad_neg, 0);
        if (req_cnt == 0) chk(!bad_first, "R2", "first request at begin value 0", bad_first, 0);
        req_cnt++;
        repeat ((req_cnt + seed) % 3) @(negedge clk);
        tst_req_ready = 1'b1;
        @(negedge clk);
        tst_req_ready = 1'b0;
        for (int k = 0; k < cfg_ncs; k++) begin
          repeat ((k + req_cnt + seed) % 2) @(negedge clk);
          for (int i = 0; i < NL; i++) begin
            if (!lane_on(i)) begin
              tst_rsp_pass[i] = 1'b0; tst_rsp_alt_pass[i] = 1'b0;
            end else begin
              p = cs_pass(i, d[i], k);
              tst_rsp_pass[i]     = (d[i] >= 0) ? p : !p;
              tst_rsp_alt_pass[i] = (d[i] < 0)  ? p : !p;
            end
          end
          tst_rsp_last  = (k == cfg_ncs - 1);
          tst_rsp_valid = 1'b1;
          while (!tst_rsp_ready) @(negedge clk);
          @(negedge clk);
          tst_rsp_valid = 1'b0;
          tst_rsp_last  = 1'b0;
        end
      end
    end
  end

  task automatic run_case(input bit rd, input bit ecc, input int ncs, input string tag);
    bit e;
    int lo [NL];
    int hi [NL];
    int nreq, a;
    cfg_rd = rd; cfg_ecc = ecc; cfg_ncs = ncs;
    model(e, lo, hi, nreq);
    req_cnt = 0;
    @(negedge clk);
    rd_dir = rd; ecc_en = ecc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy low with done", busy, 0);
    chk(err == e, (e ? "R4" : tag), "error flag", err, e);
    chk(req_cnt == nreq, "R10", "tests issued", req_cnt, nreq);
    if (!e) begin
      for (int i = 0; i < NL; i++) if (lane_on(i)) begin
        a = int'($signed(eye_lo[i*DW +: DW]));
        chk(a == lo[i], tag, $sformatf("R3 lower edge lane %0d", i), a, lo[i]);
        a = int'($signed(eye_hi[i*DW +: DW]));
        chk(a == hi[i], tag, $sformatf("R7 upper edge lane %0d", i), a, hi[i]);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R1", "done is one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(done == 0, "R1", "reset done", done, 0);
    chk(tst_req_valid == 0, "R11", "reset request valid", tst_req_valid, 0);
    chk(tst_rsp_ready == 0, "R11", "reset response ready", tst_rsp_ready, 0);
    chk(eye_lo == '0, "R1", "reset lower edges", 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R7 staggered write windows
    for (int i = 0; i < NL; i++) begin eye_l[i] = 2 + i; eye_r[i] = 20 + i; end
    run_case(0, 1, 1, "R7");
    // R8 R9 shared delay, ECC lane off
    run_case(0, 0, 2, "R8");
    run_case(0, 0, 3, "R9");
    // R4 R10 window between coarse points
    eye_l[3] = 5; eye_r[3] = 6;
    run_case(0, 1, 1, "R10");
    // R6 read windows around zero
    for (int i = 0; i < NL; i++) begin eye_l[i] = -10 - i; eye_r[i] = 15 + i; end
    run_case(1, 1, 3, "R6");
    // R5 window past the negative limit
    eye_l[0] = -40;
    run_case(1, 1, 1, "R5");
    // R4 window wholly negative
    eye_r[2] = -3;
    run_case(1, 1, 1, "R4");
    // R5 full range windows pin at both limits
    for (int i = 0; i < NL; i++) begin eye_l[i] = 0; eye_r[i] = 31; end
    run_case(0, 1, 1, "R5");
    // R1 start while busy is ignored: second start mid-run leaves result unchanged
    for (int i = 0; i < NL; i++) begin eye_l[i] = 3 + (i % 4); eye_r[i] = 24 - (i % 3); end
    fork
      run_case(0, 1, 1, "R1");
      begin
        repeat (20) @(negedge clk);
        rd_dir = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rd_dir = 1'b0;
      end
    join

    // sweep
    for (int rd = 0; rd < 2; rd++)
      for (int ecc = 0; ecc < 2; ecc++)
        for (int p = 0; p < 10; p++) begin
          seed = p + rd * 3;
          for (int i = 0; i < NL; i++) begin
            eye_l[i] = (rd ? -20 : 0) + ((i * 7 + p * 11) % 13);
            eye_r[i] = eye_l[i] + (rd ? 20 : 6) + ((i * 5 + p * 3) % 17);
          end
          run_case(rd[0], ecc[0], (p % 3) + 1, rd ? "R6" : "R3");
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule